// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block holds the interrupt state for a group of DMA channels. Each channel raises single-cycle event pulses when a transfer finishes or when an abort has been accepted. Every channel offers four register views: a live view of the events seen in the last cycle, a sticky request register that software clears by writing ones, an enable mask, and a read-only detect view that is the request masked by the enable.

An abort sets both the abort flag and the done flag. Software must therefore use its own record of whether it asked for an abort to tell a completion from an abort. Software can also poll the abort flag in the request view with its interrupt left disabled. Each channel drives a registered level interrupt. These levels are ORed onto one shared line, so a handler that finds a zero detect value knows another channel raised the line.

Registers are reached over a simple single-cycle write and one-cycle read port. Each channel sits in its own window above a common base.

Top module: `irqs_unit`

## Requirements
- R1: After reset, every register of every channel reads zero, and every channel interrupt and the shared line are low.
- R2: A done pulse on a channel sets bit 1 of its request register. The live status view shows bit 1 in the cycle after the pulse and shows zero again one cycle later.
- R3: An abort pulse sets bit 13 and bit 1 of the request register, and the live status view shows 0x2002. The request bits can be read while the enable mask is zero, and the channel interrupt then stays low.
- R4: Writing the request register clears each bit written as 1. Bits written as 0 keep their value.
- R5: If an event sets a request bit in the same cycle that a write of 1 clears it, the bit ends up set.
- R6: The enable mask holds only bits 1 and 13. Every other bit reads zero, and writes to those bits are ignored.
- R7: The detect view reads request AND enable. Writes to the detect and status views change no register.
- R8: A channel interrupt is high exactly one cycle after its detect value becomes non-zero, and low one cycle after it becomes zero.
- R9: The shared interrupt line is high while any channel interrupt is high.
- R10: Channel c occupies 0x100 + 0x40*c. Within that window status is at +0x10, request at +0x14, enable at +0x18 and detect at +0x1C. Any other address reads zero and ignores writes, and a write to one channel leaves the others unchanged.
- R11: A read strobe gives rd_valid and rd_data in the next cycle, holding the register value from before that clock edge. rd_valid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_done | input | NCH | Per-channel transfer-finished pulse |
| evt_abort | input | NCH | Per-channel abort-accepted pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data strobe, one cycle after bus_rd |
| ch_irq | output | NCH | Per-channel level interrupt |
| irq_shared | output | 1 | OR of all channel interrupts |

## Verification
A request flag that is lost or stuck shows up at the next read of the request or detect view. When the enable bit is set, it also shows on ch_irq within two cycles of the event or clear. A wrong set-versus-clear priority leaves the request bit reading zero right after a collision write. A decode fault shows as a write landing in a neighbouring channel, which a read of that channel's enable exposes within a few cycles. Interrupt timing is sampled cycle by cycle around each enable change, so a missing or extra register stage on the interrupt path is seen at once.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

    localparam int DONE_BIT  = 1;
    localparam int ABORT_BIT = 13;
    localparam int WORD_W    = 32;

    localparam int OFF_STAT = 'h10;
    localparam int OFF_REQ  = 'h14;
    localparam int OFF_EN   = 'h18;
    localparam int OFF_DET  = 'h1C;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic abort;
        logic done;
    } evflags_t;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_STAT,
        RK_REQ,
        RK_EN,
        RK_DET
    } regkind_t;

    function automatic word_t flags_to_word(evflags_t f);
        word_t w;
        w            = '0;
        w[DONE_BIT]  = f.done;
        w[ABORT_BIT] = f.abort;
        return w;
    endfunction

    function automatic evflags_t word_to_flags(word_t w);
        evflags_t f;
        f.done  = w[DONE_BIT];
        f.abort = w[ABORT_BIT];
        return f;
    endfunction

endpackage

// File: rtl/irqs_decode.sv
module irqs_decode
    import irqs_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int ADDR_W  = 12,
    parameter int CH_BASE = 'h100,
    parameter int STRIDE  = 'h40
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NCH-1:0]    ch_sel,
    output regkind_t          kind
);
    localparam int SLOG   = $clog2(STRIDE);
    localparam int SPAN   = NCH * STRIDE;

    logic [ADDR_W-1:0] rel;
    logic              in_range;
    logic [SLOG-1:0]   off;

    always_comb begin
        rel      = addr - ADDR_W'(CH_BASE);
        in_range = (int'(addr) >= CH_BASE) && (int'(rel) < SPAN);
        off      = rel[SLOG-1:0];
        kind     = RK_NONE;
        ch_sel   = '0;
        if (in_range) begin
            case (int'(off))
                OFF_STAT: kind = RK_STAT;
                OFF_REQ:  kind = RK_REQ;
                OFF_EN:   kind = RK_EN;
                OFF_DET:  kind = RK_DET;
                default:  kind = RK_NONE;
            endcase
            if (kind != RK_NONE) begin
                for (int c = 0; c < NCH; c++) begin
                    if (int'(rel[ADDR_W-1:SLOG]) == c) ch_sel[c] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/irqs_chan.sv
module irqs_chan
    import irqs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     evt_done,
    input  logic     evt_abort,
    input  logic     wr_req,
    input  logic     wr_en,
    input  evflags_t wflags,
    output evflags_t stat_q,
    output evflags_t req_q,
    output evflags_t en_q,
    output evflags_t det,
    output logic     irq_q
);
    evflags_t set_v;
    evflags_t clr_v;
    evflags_t req_nxt;

    always_comb begin
        set_v.abort = evt_abort;
        set_v.done  = evt_done | evt_abort;
        clr_v       = wr_req ? wflags : evflags_t'('0);
        // a set in the same cycle overrides a clear
        req_nxt     = evflags_t'((req_q & ~clr_v) | set_v);
        det         = evflags_t'(req_q & en_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            req_q  <= '0;
            en_q   <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= set_v;
            req_q  <= req_nxt;
            if (wr_en) en_q <= wflags;
            irq_q  <= |det;
        end
    end
endmodule

// File: rtl/irqs_rdmux.sv
module irqs_rdmux
    import irqs_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd,
    input  regkind_t           kind,
    input  logic [NCH-1:0]     ch_sel,
    input  evflags_t [NCH-1:0] stat_v,
    input  evflags_t [NCH-1:0] req_v,
    input  evflags_t [NCH-1:0] en_v,
    input  evflags_t [NCH-1:0] det_v,
    output word_t              rd_data,
    output logic               rd_valid
);
    evflags_t pick;

    always_comb begin
        pick = '0;
        for (int c = 0; c < NCH; c++) begin
            if (ch_sel[c]) begin
                case (kind)
                    RK_STAT: pick = stat_v[c];
                    RK_REQ:  pick = req_v[c];
                    RK_EN:   pick = en_v[c];
                    RK_DET:  pick = det_v[c];
                    default: pick = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd;
            rd_data  <= rd ? flags_to_word(pick) : '0;
        end
    end
endmodule

// File: rtl/irqs_unit.sv
module irqs_unit
    import irqs_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int ADDR_W  = 12,
    parameter int CH_BASE = 'h100,
    parameter int STRIDE  = 'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    evt_done,
    input  logic [NCH-1:0]    evt_abort,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic [NCH-1:0]    ch_irq,
    output logic              irq_shared
);
    logic [NCH-1:0]     ch_sel;
    regkind_t           kind;
    evflags_t           wflags;
    evflags_t [NCH-1:0] stat_v;
    evflags_t [NCH-1:0] req_v;
    evflags_t [NCH-1:0] en_v;
    evflags_t [NCH-1:0] det_v;

    assign wflags = word_to_flags(bus_wdata);

    irqs_decode #(
        .NCH(NCH), .ADDR_W(ADDR_W), .CH_BASE(CH_BASE), .STRIDE(STRIDE)
    ) u_dec (
        .addr(bus_addr),
        .ch_sel(ch_sel),
        .kind(kind)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic wr_req_c;
        logic wr_en_c;
        assign wr_req_c = bus_wr && ch_sel[c] && (kind == RK_REQ);
        assign wr_en_c  = bus_wr && ch_sel[c] && (kind == RK_EN);

        irqs_chan u_chan (
            .clk(clk),
            .rst(rst),
            .evt_done(evt_done[c]),
            .evt_abort(evt_abort[c]),
            .wr_req(wr_req_c),
            .wr_en(wr_en_c),
            .wflags(wflags),
            .stat_q(stat_v[c]),
            .req_q(req_v[c]),
            .en_q(en_v[c]),
            .det(det_v[c]),
            .irq_q(ch_irq[c])
        );
    end

    irqs_rdmux #(.NCH(NCH)) u_rd (
        .clk(clk),
        .rst(rst),
        .rd(bus_rd),
        .kind(kind),
        .ch_sel(ch_sel),
        .stat_v(stat_v),
        .req_v(req_v),
        .en_v(en_v),
        .det_v(det_v),
        .rd_data(rd_data),
        .rd_valid(rd_valid)
    );

    assign irq_shared = |ch_irq;
endmodule

// File: rtl/irqs_unit_chk.sv
module irqs_unit_chk
    import irqs_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [NCH-1:0]     evt_done,
    input logic [NCH-1:0]     evt_abort,
    input logic               bus_rd,
    input logic               rd_valid,
    input logic [NCH-1:0]     ch_irq,
    input logic               irq_shared,
    input evflags_t [NCH-1:0] req_v,
    input evflags_t [NCH-1:0] det_v
);
    a_r11_rd_strobe: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> rd_valid);
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !rd_valid);
    a_r9_shared_line: assert property (@(posedge clk) disable iff (rst)
        (ch_irq != '0) |-> irq_shared);

    for (genvar c = 0; c < NCH; c++) begin : g_a
        a_r2_done_sets: assert property (@(posedge clk) disable iff (rst)
            evt_done[c] |=> req_v[c].done);
        a_r3_abort_sets_both: assert property (@(posedge clk) disable iff (rst)
            evt_abort[c] |=> (req_v[c].abort && req_v[c].done));
        a_r8_irq_follows_det: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (ch_irq[c] == $past(det_v[c] != '0)));
        a_r4_set_needs_event: assert property (@(posedge clk) disable iff (rst)
            $rose(req_v[c].done) |-> $past(evt_done[c] || evt_abort[c]));
    end
endmodule

bind irqs_unit irqs_unit_chk #(.NCH(NCH)) u_chk (
    .clk(clk),
    .rst(rst),
    .evt_done(evt_done),
    .evt_abort(evt_abort),
    .bus_rd(bus_rd),
    .rd_valid(rd_valid),
    .ch_irq(ch_irq),
    .irq_shared(irq_shared),
    .req_v(req_v),
    .det_v(det_v)
);

// File: tb/test_irqs_unit.sv
module test_irqs_unit;
    localparam int NCH    = 4;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    evt_done = '0;
    logic [NCH-1:0]    evt_abort = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       rd_data;
    logic              rd_valid;
    logic [NCH-1:0]    ch_irq;
    logic              irq_shared;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;
    rd_item_t sb[$];

    always #2 clk = ~clk;

    irqs_unit #(.NCH(NCH), .ADDR_W(ADDR_W)) i_irqs_unit (
        .clk(clk), .rst(rst),
        .evt_done(evt_done), .evt_abort(evt_abort),
        .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .ch_irq(ch_irq), .irq_shared(irq_shared)
    );

    function automatic logic [ADDR_W-1:0] a(int ch, int off);
        return ADDR_W'('h100 + 'h40 * ch + off);
    endfunction

    // monitor: pops expected read results as they come back
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            n_cmp++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL R11: unexpected rd_valid, data %h expected no read", rd_data);
            end else begin
                rd_item_t it;
                it = sb.pop_front();
                if (rd_data !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: read %h expected %h", it.tag, rd_data, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(logic [ADDR_W-1:0] ad, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = ad; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] ad, logic [31:0] e, string tag);
        rd_item_t it;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        bus_rd = 1'b1; bus_addr = ad;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic chk(logic [31:0] act, logic [31:0] e, string tag);
        n_cmp++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, e);
        end
    endtask

    task automatic pulse(int ch, bit abrt);
        if (abrt) evt_abort[ch] = 1'b1; else evt_done[ch] = 1'b1;
        tick();
        evt_abort = '0; evt_done = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk(32'(ch_irq), 0, "R1 ch_irq");
        chk(32'(irq_shared), 0, "R1 shared");
        for (int c = 0; c < NCH; c += 3) begin
            rd(a(c, 'h10), 0, "R1 stat");
            rd(a(c, 'h14), 0, "R1 req");
            rd(a(c, 'h18), 0, "R1 en");
            rd(a(c, 'h1C), 0, "R1 det");
        end

        // R2 done event on channel 0
        pulse(0, 0);
        rd(a(0, 'h10), 32'h2, "R2 live status");
        rd(a(0, 'h10), 32'h0, "R2 live status clears");
        rd(a(0, 'h14), 32'h2, "R2 request");
        rd(a(0, 'h1C), 32'h0, "R7 detect masked");
        chk(32'(ch_irq[0]), 0, "R8 masked irq");

        // R6 / R8 / R9 enable
        wr(a(0, 'h18), 32'hFFFF_FFFF);
        chk(32'(ch_irq[0]), 0, "R8 one-cycle delay");
        tick();
        chk(32'(ch_irq[0]), 1, "R8 irq raised");
        chk(32'(irq_shared), 1, "R9 shared raised");
        rd(a(0, 'h18), 32'h2002, "R6 enable bits");
        rd(a(0, 'h1C), 32'h2, "R7 detect");

        // R4 write-one-to-clear
        wr(a(0, 'h14), 32'h0);
        rd(a(0, 'h14), 32'h2, "R4 zero keeps");
        wr(a(0, 'h14), 32'h2);
        chk(32'(ch_irq[0]), 1, "R8 fall delay");
        tick();
        chk(32'(ch_irq[0]), 0, "R8 irq dropped");
        chk(32'(irq_shared), 0, "R9 shared dropped");
        rd(a(0, 'h14), 32'h0, "R4 cleared");

        // R3 abort on channel 1, polled with interrupt disabled
        pulse(1, 1);
        rd(a(1, 'h10), 32'h2002, "R3 live status");
        rd(a(1, 'h14), 32'h2002, "R3 request both");
        chk(32'(ch_irq[1]), 0, "R3 no irq when masked");
        wr(a(1, 'h14), 32'h2000);
        rd(a(1, 'h14), 32'h2, "R4 partial clear");
        wr(a(1, 'h14), 32'h2);
        rd(a(1, 'h14), 32'h0, "R4 full clear");

        // R5 set wins over same-cycle clear
        evt_done[2] = 1'b1;
        wr(a(2, 'h14), 32'h2);
        evt_done = '0;
        rd(a(2, 'h14), 32'h2, "R5 set wins");
        wr(a(2, 'h14), 32'h2);

        // R7 writes to read-only views
        wr(a(2, 'h10), 32'hFFFF_FFFF);
        wr(a(2, 'h1C), 32'hFFFF_FFFF);
        rd(a(2, 'h14), 32'h0, "R7 req untouched");
        rd(a(2, 'h18), 32'h0, "R7 en untouched");
        rd(a(2, 'h1C), 32'h0, "R7 det untouched");

        // R6 unused bits, R10 decode
        wr(a(3, 'h18), 32'h0000_0004);
        rd(a(3, 'h18), 32'h0, "R6 unused bit ignored");
        wr(a(3, 'h18), 32'h2);
        rd(a(3, 'h18), 32'h2, "R10 ch3 enable");
        rd(a(2, 'h18), 32'h0, "R10 neighbour isolated");
        wr(a(4, 'h18), 32'hFFFF_FFFF);
        wr(12'h018, 32'hFFFF_FFFF);
        rd(a(4, 'h18), 32'h0, "R10 beyond window");
        rd(12'h018, 32'h0, "R10 below base");
        rd(a(0, 'h20), 32'h0, "R10 hole");
        rd(a(2, 'h18), 32'h0, "R10 stray write ignored");

        // R9 shared line with two channels
        pulse(3, 0);
        chk(32'(ch_irq[3]), 0, "R8 ch3 delay");
        tick();
        chk(32'(ch_irq[3]), 1, "R8 ch3 raised");
        pulse(0, 0);
        tick();
        chk(32'(ch_irq), 32'h9, "R9 two channels");
        wr(a(3, 'h14), 32'h2);
        tick();
        chk(32'(ch_irq), 32'h1, "R9 one remaining");
        chk(32'(irq_shared), 1, "R9 shared held");
        wr(a(0, 'h14), 32'h2);
        tick();
        chk(32'(irq_shared), 0, "R9 shared low");

        // R11 no stray strobes
        tick();
        chk(32'(rd_valid), 0, "R11 idle");
        chk(32'(sb.size()), 0, "R11 all reads returned");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule